// File: doc/BRIEF.md
# Dual Multiply-Accumulate with Half-Word Writeback

This block holds two multiply-accumulate lanes that run side by side. On every clock each lane forms the product of two 16-bit operands. It then leaves its wide accumulator alone, loads the product into it, adds the product to it or subtracts the product from it. From the updated accumulator it extracts a 16-bit result. That result is rounded or truncated, scaled when the mode asks for it, and clamped to the signed or unsigned 16-bit range.

Lane 0 writes the low half of a 32-bit destination word and lane 1 writes the high half, each under its own write enable. One rounding-mode input, shared by both lanes, chooses between biased and round-half-to-even handling. Lane 1 has an extra option that multiplies a signed first operand by an unsigned second operand. Every lane also keeps a sticky flag that records clipping.

All outputs are registered. The accumulators and the destination halves take their new values on the same clock edge that the operation is presented on.

Top module: `dual_mac_hw`

## Requirements
- R1: After synchronous reset both accumulators, the destination word and both saturation flags read zero.
- R2: The operation code per lane is 0 = hold, 1 = load product, 2 = add product and 3 = subtract product. The accumulator is 40-bit two's complement, wraps on overflow, and shows the new value one clock after the operation is presented.
- R3: Extraction mode codes: 0 signed fraction, 1 unsigned fraction, 2 signed integer, 3 unsigned integer, 4 truncating signed fraction, 5 truncating unsigned fraction, 6 doubled signed fraction, 7 doubled signed integer, 8 signed integer high half. Modes 1, 3 and 5 multiply the operands as unsigned; all other modes multiply them as signed. Modes 0, 4 and 6 double the product, except that 0x8000 times 0x8000 gives 0x7FFFFFFF.
- R4: When the mixed option on lane 1 is set, lane 1 multiplies a signed first operand by an unsigned second operand and does not double the product. Lane 0 has no such option.
- R5: Modes 0, 1, 6 and 8 take accumulator bits [31:16] and round on bits [15:0]. With the rounding-mode input at 0, a remainder of 0x8000 or more rounds up. With it at 1, a remainder above 0x8000 rounds up, and an exact 0x8000 rounds up only if the kept value is odd.
- R6: Modes 4 and 5 take accumulator bits [31:16] and drop the remainder (floor).
- R7: Modes 2 and 3 take the accumulator value itself as the result. Mode 8 takes bits [31:16] with rounding.
- R8: Modes 6 and 7 double the accumulator value before extraction.
- R9: Signed modes clamp the result to 0x8000..0x7FFF. Unsigned modes clamp it to 0x0000..0xFFFF, and a negative accumulator gives 0x0000.
- R10: Lane 0 writes dst[15:0] and lane 1 writes dst[31:16], each only when its write enable is high. A half whose lane is not enabled keeps its value.
- R11: A lane's saturation flag goes high when an enabled write is clipped. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rnd_unbiased | input | 1 | 1 = round half to even, 0 = round half up |
| l0_a | input | 16 | Lane 0 first operand |
| l0_b | input | 16 | Lane 0 second operand |
| l0_op | input | 2 | Lane 0 accumulator operation |
| l0_mode | input | 4 | Lane 0 extraction mode |
| l0_we | input | 1 | Lane 0 write enable for dst[15:0] |
| l1_a | input | 16 | Lane 1 first operand |
| l1_b | input | 16 | Lane 1 second operand |
| l1_op | input | 2 | Lane 1 accumulator operation |
| l1_mode | input | 4 | Lane 1 extraction mode |
| l1_mix | input | 1 | Lane 1 signed-by-unsigned multiply |
| l1_we | input | 1 | Lane 1 write enable for dst[31:16] |
| dst | output | 32 | Packed destination word |
| acc0 | output | 40 | Lane 0 accumulator |
| acc1 | output | 40 | Lane 1 accumulator |
| sat | output | 2 | Sticky saturation flags, bit n for lane n |

## Verification
The bench builds the block with its default widths, a 16-bit operand and a 40-bit accumulator. With these widths the half-way remainder 0x8000 sits at a fixed spot, so exact ties can be set up directly by loading an integer product and then holding it under a rounding mode. The 8 guard bits let sums and doubled values above the 32-bit range stay in the accumulator, so the bench can clip them at the 16-bit result without any wrap. The double-minimum operand pair and the signed-by-unsigned product fit the 34-bit product path exactly, which makes their boundary values directly visible on the accumulator ports.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_ADD  = 2'd2,
    OP_SUB  = 2'd3
  } acc_op_e;

  // extraction mode codes
  localparam logic [3:0] XM_FS    = 4'd0;
  localparam logic [3:0] XM_FU    = 4'd1;
  localparam logic [3:0] XM_IS    = 4'd2;
  localparam logic [3:0] XM_IU    = 4'd3;
  localparam logic [3:0] XM_TS    = 4'd4;
  localparam logic [3:0] XM_TU    = 4'd5;
  localparam logic [3:0] XM_FS2   = 4'd6;
  localparam logic [3:0] XM_IS2   = 4'd7;
  localparam logic [3:0] XM_IHI   = 4'd8;

  function automatic logic mode_unsigned(input logic [3:0] m);
    return (m == XM_FU) || (m == XM_IU) || (m == XM_TU);
  endfunction

  function automatic logic mode_dbl_prod(input logic [3:0] m);
    return (m == XM_FS) || (m == XM_TS) || (m == XM_FS2);
  endfunction

  function automatic logic mode_rounds(input logic [3:0] m);
    return (m == XM_FS) || (m == XM_FU) || (m == XM_FS2) || (m == XM_IHI);
  endfunction

  function automatic logic mode_high(input logic [3:0] m);
    return !((m == XM_IS) || (m == XM_IU) || (m == XM_IS2));
  endfunction

  function automatic logic mode_scaled(input logic [3:0] m);
    return (m == XM_FS2) || (m == XM_IS2);
  endfunction
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DW = 16,
  parameter int PW = 2 * DW + 2
) (
  input  logic [DW-1:0]        a,
  input  logic [DW-1:0]        b,
  input  logic                 a_sgn,
  input  logic                 b_sgn,
  input  logic                 dbl,
  output logic signed [PW-1:0] prod
);
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [PW-1:0] PMAX = {{(PW-2*DW+1){1'b0}}, {(2*DW-1){1'b1}}};

  logic signed [DW:0]   ax;
  logic signed [DW:0]   bx;
  logic signed [PW-1:0] raw;
  logic                 corner;

  assign ax     = {a_sgn & a[DW-1], a};
  assign bx     = {b_sgn & b[DW-1], b};
  assign raw    = ax * bx;
  assign corner = dbl && a_sgn && b_sgn && (a == MINV) && (b == MINV);

  always_comb begin
    if (corner)   prod = PMAX;
    else if (dbl) prod = raw <<< 1;
    else          prod = raw;
  end
endmodule

// File: rtl/mac_extract.sv
module mac_extract
  import dmac_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic signed [AW-1:0] acc,
  input  logic [3:0]           mode,
  input  logic                 rnd_unb,
  output logic [DW-1:0]        res,
  output logic                 clip
);
  localparam int VW = AW + 1;
  localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [VW-1:0] S_MAX = $signed({{(VW-DW+1){1'b0}}, {(DW-1){1'b1}}});
  localparam logic signed [VW-1:0] S_MIN = ~S_MAX;
  localparam logic signed [VW-1:0] U_MAX = $signed({{(VW-DW){1'b0}}, {DW{1'b1}}});

  logic signed [VW-1:0] v;
  logic signed [VW-1:0] q;
  logic [DW-1:0]        frac;
  logic                 bump;

  always_comb begin
    v    = mode_scaled(mode) ? {acc, 1'b0} : {acc[AW-1], acc};
    frac = '0;
    bump = 1'b0;
    if (mode_high(mode)) begin
      q    = v >>> DW;
      frac = v[DW-1:0];
      if (mode_rounds(mode))
        bump = (frac > HALF) || ((frac == HALF) && (!rnd_unb || q[0]));
      if (bump) q = q + VW'(1);
    end else begin
      q = v;
    end

    clip = 1'b0;
    res  = q[DW-1:0];
    if (mode_unsigned(mode)) begin
      if (q[VW-1]) begin
        res  = '0;
        clip = 1'b1;
      end else if (q > U_MAX) begin
        res  = '1;
        clip = 1'b1;
      end
    end else begin
      if (q > S_MAX) begin
        res  = S_MAX[DW-1:0];
        clip = 1'b1;
      end else if (q < S_MIN) begin
        res  = S_MIN[DW-1:0];
        clip = 1'b1;
      end
    end
  end

  always_comb begin
    if (clip)
      AST_CLIP_AT_LIMIT: assert ((res == '0) || (res == '1) ||
                                 (res == S_MAX[DW-1:0]) || (res == S_MIN[DW-1:0])); // R9
  end
endmodule

// File: rtl/mac_lane.sv
module mac_lane
  import dmac_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 40,
  parameter bit HAS_MIX = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DW-1:0]        a,
  input  logic [DW-1:0]        b,
  input  logic [1:0]           op,
  input  logic [3:0]           mode,
  input  logic                 mix,
  input  logic                 we,
  input  logic                 rnd_unb,
  output logic signed [AW-1:0] acc_q,
  output logic [DW-1:0]        half_q,
  output logic                 sat_q
);
  localparam int PW = 2 * DW + 2;

  acc_op_e              op_e;
  logic                 mix_on;
  logic                 uns;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;
  logic signed [AW-1:0] acc_nx;
  logic [DW-1:0]        res;
  logic                 clip;

  assign op_e     = acc_op_e'(op);
  assign mix_on   = HAS_MIX && mix;
  assign uns      = mode_unsigned(mode);
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  mac_mult #(.DW(DW), .PW(PW)) u_mult (
    .a     (a),
    .b     (b),
    .a_sgn (mix_on | ~uns),
    .b_sgn (~mix_on & ~uns),
    .dbl   (~mix_on & mode_dbl_prod(mode)),
    .prod  (prod)
  );

  always_comb begin
    case (op_e)
      OP_LOAD: acc_nx = prod_ext;
      OP_ADD:  acc_nx = acc_q + prod_ext;
      OP_SUB:  acc_nx = acc_q - prod_ext;
      default: acc_nx = acc_q;
    endcase
  end

  mac_extract #(.DW(DW), .AW(AW)) u_ext (
    .acc     (acc_nx),
    .mode    (mode),
    .rnd_unb (rnd_unb),
    .res     (res),
    .clip    (clip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      half_q <= '0;
      sat_q  <= 1'b0;
    end else begin
      acc_q <= acc_nx;
      if (we) half_q <= res;
      if (we && clip) sat_q <= 1'b1;
    end
  end

  AST_HOLD_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_HOLD) |=> $stable(acc_q)); // R2
  AST_LOAD_TAKES_PROD: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_LOAD) |=> (acc_q == $past(prod_ext))); // R2
  AST_NO_WE_KEEPS_HALF: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(half_q)); // R10
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (rst)
    sat_q |=> sat_q); // R11
endmodule

// File: rtl/dual_mac_hw.sv
module dual_mac_hw #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rnd_unbiased,
  input  logic [DW-1:0]   l0_a,
  input  logic [DW-1:0]   l0_b,
  input  logic [1:0]      l0_op,
  input  logic [3:0]      l0_mode,
  input  logic            l0_we,
  input  logic [DW-1:0]   l1_a,
  input  logic [DW-1:0]   l1_b,
  input  logic [1:0]      l1_op,
  input  logic [3:0]      l1_mode,
  input  logic            l1_mix,
  input  logic            l1_we,
  output logic [2*DW-1:0] dst,
  output logic [AW-1:0]   acc0,
  output logic [AW-1:0]   acc1,
  output logic [1:0]      sat
);
  localparam int NL = 2;

  logic [DW-1:0] a_v    [NL];
  logic [DW-1:0] b_v    [NL];
  logic [1:0]    op_v   [NL];
  logic [3:0]    mode_v [NL];
  logic          mix_v  [NL];
  logic          we_v   [NL];
  logic [AW-1:0] acc_v  [NL];
  logic [DW-1:0] half_v [NL];
  logic [NL-1:0] sat_v;

  assign a_v[0] = l0_a;    assign a_v[1] = l1_a;
  assign b_v[0] = l0_b;    assign b_v[1] = l1_b;
  assign op_v[0] = l0_op;  assign op_v[1] = l1_op;
  assign mode_v[0] = l0_mode; assign mode_v[1] = l1_mode;
  assign mix_v[0] = 1'b0;  assign mix_v[1] = l1_mix;
  assign we_v[0] = l0_we;  assign we_v[1] = l1_we;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    mac_lane #(.DW(DW), .AW(AW), .HAS_MIX(g == 1)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .a       (a_v[g]),
      .b       (b_v[g]),
      .op      (op_v[g]),
      .mode    (mode_v[g]),
      .mix     (mix_v[g]),
      .we      (we_v[g]),
      .rnd_unb (rnd_unbiased),
      .acc_q   (acc_v[g]),
      .half_q  (half_v[g]),
      .sat_q   (sat_v[g])
    );
  end

  assign dst  = {half_v[1], half_v[0]};
  assign acc0 = acc_v[0];
  assign acc1 = acc_v[1];
  assign sat  = sat_v;
endmodule

// File: tb/dual_mac_hw_test.sv
`timescale 1ns/1ps
module dual_mac_hw_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rnd_unbiased = 1'b0;
  logic [15:0] l0_a = '0, l0_b = '0, l1_a = '0, l1_b = '0;
  logic [1:0]  l0_op = '0, l1_op = '0;
  logic [3:0]  l0_mode = '0, l1_mode = '0;
  logic        l0_we = 1'b0, l1_we = 1'b0, l1_mix = 1'b0;
  logic [31:0] dst;
  logic [39:0] acc0, acc1;
  logic [1:0]  sat;

  always #2 clk = ~clk;

  dual_mac_hw uut (
    .clk(clk), .rst(rst), .rnd_unbiased(rnd_unbiased),
    .l0_a(l0_a), .l0_b(l0_b), .l0_op(l0_op), .l0_mode(l0_mode), .l0_we(l0_we),
    .l1_a(l1_a), .l1_b(l1_b), .l1_op(l1_op), .l1_mode(l1_mode), .l1_mix(l1_mix),
    .l1_we(l1_we), .dst(dst), .acc0(acc0), .acc1(acc1), .sat(sat)
  );

  typedef struct packed {
    logic [31:0] dst;
    logic [39:0] a0;
    logic [39:0] a1;
    logic [1:0]  sat;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;

  longint      m_acc [2];
  logic [15:0] m_half [2];
  logic [1:0]  m_sat;

  task automatic check(input string tag, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic longint s16(input logic [15:0] x);
    return longint'($signed(x));
  endfunction

  function automatic longint wrap40(input longint x);
    logic [39:0] t;
    t = x[39:0];
    return longint'($signed(t));
  endfunction

  function automatic longint prod_m(input logic [15:0] a, input logic [15:0] b,
                                    input int mode, input bit mix);
    if (mix) return s16(a) * longint'(b);
    if (mode inside {1, 3, 5}) return longint'(a) * longint'(b);
    if (mode inside {0, 4, 6}) begin
      if (a == 16'h8000 && b == 16'h8000) return 64'h7FFF_FFFF;
      return 2 * s16(a) * s16(b);
    end
    return s16(a) * s16(b);
  endfunction

  task automatic extract_m(input longint acc, input int mode, input bit unb,
                           output logic [15:0] r, output bit clip);
    longint v, q, fr, lo, hi;
    v = (mode inside {6, 7}) ? acc * 2 : acc;
    if (!(mode inside {2, 3, 7})) begin
      q  = v >>> 16;
      fr = v & 64'hFFFF;
      if (mode inside {0, 1, 6, 8})
        if (fr > 32768 || (fr == 32768 && (!unb || q[0]))) q = q + 1;
    end else q = v;
    if (mode inside {1, 3, 5}) begin lo = 0; hi = 65535; end
    else begin lo = -32768; hi = 32767; end
    clip = 1'b0;
    if (q > hi) begin q = hi; clip = 1'b1; end
    if (q < lo) begin q = lo; clip = 1'b1; end
    r = q[15:0];
  endtask

  task automatic lane_m(input int i, input logic [15:0] a, input logic [15:0] b,
                        input int op, input int mode, input bit mix, input bit we,
                        input bit unb);
    longint p;
    logic [15:0] r;
    bit c;
    p = prod_m(a, b, mode, mix);
    case (op)
      1: m_acc[i] = wrap40(p);
      2: m_acc[i] = wrap40(m_acc[i] + p);
      3: m_acc[i] = wrap40(m_acc[i] - p);
      default: ;
    endcase
    extract_m(m_acc[i], mode, unb, r, c);
    if (we) begin
      m_half[i] = r;
      if (c) m_sat[i] = 1'b1;
    end
  endtask

  // drive at a falling edge, predict, push; returns at the next falling edge
  task automatic step(input string tag,
                      input logic [15:0] a0, input logic [15:0] b0, input int op0,
                      input int md0, input bit we0,
                      input logic [15:0] a1, input logic [15:0] b1, input int op1,
                      input int md1, input bit mix1, input bit we1, input bit unb);
    exp_t e;
    l0_a = a0; l0_b = b0; l0_op = op0[1:0]; l0_mode = md0[3:0]; l0_we = we0;
    l1_a = a1; l1_b = b1; l1_op = op1[1:0]; l1_mode = md1[3:0]; l1_mix = mix1;
    l1_we = we1; rnd_unbiased = unb;
    lane_m(0, a0, b0, op0, md0, 1'b0, we0, unb);
    lane_m(1, a1, b1, op1, md1, mix1, we1, unb);
    e.dst = {m_half[1], m_half[0]};
    e.a0  = m_acc[0][39:0];
    e.a1  = m_acc[1][39:0];
    e.sat = m_sat;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic do_reset();
    l0_op = '0; l1_op = '0; l0_we = 1'b0; l1_we = 1'b0; l1_mix = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_acc[0] = 0; m_acc[1] = 0; m_half[0] = '0; m_half[1] = '0; m_sat = '0;
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    exp_t  e;
    string t;
    #1;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, "dst", {8'h0, dst}, {8'h0, e.dst});
      check(t, "acc0", acc0, e.a0);
      check(t, "acc1", acc1, e.a1);
      check(t, "sat", {38'h0, sat}, {38'h0, e.sat});
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1", "dst", {8'h0, dst}, 40'h0);
    check("R1", "acc0", acc0, 40'h0);
    check("R1", "acc1", acc1, 40'h0);
    check("R1", "sat", {38'h0, sat}, 40'h0);

    // R3 signed fraction doubling, unsigned fraction
    step("R3", 16'h4000, 16'h4000, 1, 0, 1, 16'hFFFF, 16'hFFFF, 1, 1, 0, 1, 0);
    // R3 double-minimum corner (rounds up past limit, clips)
    step("R3", 16'h8000, 16'h8000, 1, 0, 1, 16'h0000, 16'h0000, 0, 1, 0, 0, 0);
    // R2 add and subtract
    step("R2", 16'h0003, 16'h0005, 1, 2, 1, 16'h0007, 16'h0009, 1, 3, 0, 1, 0);
    step("R2", 16'h0003, 16'h0005, 2, 2, 1, 16'h0002, 16'h0003, 3, 3, 0, 1, 0);
    // R2 hold with writes disabled
    step("R2", 16'h7FFF, 16'h7FFF, 0, 2, 0, 16'h7FFF, 16'h7FFF, 0, 3, 0, 0, 0);
    // R4 mixed signed-by-unsigned on lane 1, lane 0 plain signed
    step("R4", 16'hFFFE, 16'hFFFF, 1, 2, 1, 16'hFFFE, 16'hFFFF, 1, 2, 1, 1, 0);
    step("R4", 16'h0010, 16'h0010, 1, 0, 1, 16'hFFFE, 16'h8000, 1, 2, 1, 1, 0);
    // R5 exact ties: load integer products quietly, then hold under rounding
    step("R5", 16'h0140, 16'h0200, 1, 2, 0, 16'h0180, 16'h0100, 1, 2, 0, 0, 0);
    step("R5", 16'h0000, 16'h0000, 0, 0, 1, 16'h0000, 16'h0000, 0, 0, 0, 1, 0);
    step("R5", 16'h0000, 16'h0000, 0, 0, 1, 16'h0000, 16'h0000, 0, 0, 0, 1, 1);
    step("R5", 16'h0000, 16'h0000, 0, 8, 1, 16'h0000, 16'h0000, 0, 1, 0, 1, 1);
    // R6 truncation vs rounding of the same tie
    step("R6", 16'h4000, 16'h4001, 1, 4, 1, 16'h4000, 16'h4001, 1, 0, 0, 1, 0);
    step("R6", 16'hFFFF, 16'h8001, 1, 5, 1, 16'h0000, 16'h0000, 0, 5, 0, 1, 0);
    // R7 integer low and high-half extraction
    step("R7", 16'h0100, 16'h0180, 1, 8, 1, 16'h0100, 16'h0180, 1, 2, 0, 1, 0);
    step("R7", 16'h0064, 16'hFF9C, 1, 2, 1, 16'h1234, 16'h0001, 1, 3, 0, 1, 0);
    // R8 doubled extraction
    step("R8", 16'h2000, 16'h2000, 1, 6, 1, 16'h0064, 16'h0064, 1, 7, 0, 1, 0);
    step("R8", 16'h0000, 16'h0000, 0, 6, 1, 16'h00C8, 16'h00C8, 1, 7, 0, 1, 1);
    // R9 unsigned overflow and negative clamp, signed guard-bit overflow
    step("R9", 16'h0100, 16'h0100, 1, 3, 1, 16'h0005, 16'h0005, 1, 3, 0, 1, 0);
    step("R9", 16'h7FFF, 16'h7FFF, 2, 0, 1, 16'h0006, 16'h0006, 3, 3, 0, 1, 0);
    step("R9", 16'h7FFF, 16'h7FFF, 2, 6, 1, 16'h8000, 16'h7FFF, 1, 2, 0, 1, 0);
    // R10 disabled half keeps value while its accumulator moves
    step("R10", 16'h0011, 16'h0011, 1, 2, 0, 16'h0022, 16'h0002, 1, 2, 0, 1, 0);
    step("R10", 16'h0001, 16'h0001, 1, 2, 1, 16'h0033, 16'h0002, 1, 2, 0, 0, 0);
    // R11 flags stay set across in-range writes
    step("R11", 16'h0002, 16'h0002, 1, 2, 1, 16'h0002, 16'h0002, 1, 2, 0, 1, 0);
    repeat (2) @(negedge clk);
    do_reset();
    check("R11", "sat cleared by reset", {38'h0, sat}, 40'h0);
    check("R1", "dst after reset", {8'h0, dst}, 40'h0);
    step("R11", 16'h0001, 16'h0001, 1, 2, 1, 16'h0001, 16'h0001, 1, 2, 0, 1, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule